// File: doc/BRIEF.md
# Serial Link Test Pattern Generator

This block sits in the transmit path of a multi-lane serial link, just ahead of the serializers. Each lane carries one 10-bit symbol per pixel clock. A 2-bit mode input chooses between two behaviours. In the first, the normal lane data passes through. In the other three, every lane's symbols are replaced with a test pattern: a PRBS7 bit stream, a slow toggle that gives runs of five zeros and five ones, or a fast toggle that alternates on every bit. One pattern engine feeds all the lanes, so in a pattern mode every lane carries the same symbol.

The symbol stream uses a valid/ready handshake. The ready signal goes straight back from the output side to the input side, and the valid signal goes straight forward. A symbol moves on a cycle when `in_valid` and `out_ready` are both high. When `out_ready` is low (back-pressure), or when no valid symbol is offered, the pattern engines hold their position. The symbol on the output then stays unchanged until the next transfer. The mode input and the clock-present flag are plain level signals.

A changeover from the fast toggle to the slow toggle is not allowed to take effect directly. Once the fast toggle has been requested, any request for the slow toggle gives normal pass-through. This lasts until the mode input has shown normal operation for at least one clock. Patterns are only sent while the clock-present flag is high. While it is low, the lanes pass their data through and the engines stand still.

Top module: `link_test_pattern_gen`

## Requirements
- R1: After reset, with mode 0 on the mode input, `out_data` equals `in_data`. The first PRBS symbol sent after reset starts from a generator history of seven ones.
- R2: In mode 0, `out_data` equals `in_data` on every lane. In every mode, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`.
- R3: Mode 1 sends a PRBS7 stream (x^7 + x^6 + 1). Bit n is bit n-6 XOR bit n-7, and the seven bits before the first one are all ones. Each transfer uses 10 consecutive bits, and the first of them goes in bit 0 of the symbol.
- R4: Mode 2 sends the slow toggle. Bits 0 to 4 of each symbol are zero and bits 5 to 9 are one, which is 10'h3E0.
- R5: Mode 3 sends the fast toggle. Bit 0 of each symbol is one and the bits then alternate, which is 10'h155.
- R6: After mode 3 has appeared on the mode input, a mode 2 request gives pass-through. This holds until mode 0 has been present on at least one rising clock edge. After that, mode 2 is honoured.
- R7: In a pattern mode, all lanes carry the same symbol.
- R8: A pattern advances only on a transfer cycle (`in_valid` and `out_ready` both high) while its mode is active. While stalled, or while another mode is selected, the pattern holds its position and resumes from there.
- R9: While `pix_clk_present` is low, `out_data` equals `in_data` whatever the mode, and the pattern engines do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk_present | input | 1 | High while a pixel clock in the supported range is detected |
| mode_sel | input | 2 | 0 pass, 1 PRBS7, 2 slow toggle, 3 fast toggle |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Input accepted when high (mirrors out_ready) |
| in_data | input | NUM_LANES*SYM_W | Normal lane symbols; lane i at bits [i*SYM_W +: SYM_W] |
| out_valid | output | 1 | Output symbol valid (mirrors in_valid) |
| out_ready | input | 1 | Downstream ready; low applies back-pressure |
| out_data | output | NUM_LANES*SYM_W | Transmitted lane symbols |

## Verification
The assertions assume three things about the inputs. First, `mode_sel` and `pix_clk_present` change only between clock edges. Second, the mode input shows mode 0 while reset is asserted. Third, the stall-hold check covers only cycles where the effective mode and the clock-present flag were the same on both sides of the edge. The bench changes every input just after the falling edge and keeps mode 0 during reset. Its stall windows keep the mode fixed, so each hold comparison is made within one mode. The stimulus mixes stalled cycles with transfer cycles so that both paths are exercised.

// File: rtl/ltpg_pkg.sv
package ltpg_pkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_PRBS = 2'd1,
    MODE_SLOW = 2'd2,
    MODE_FAST = 2'd3
  } tp_mode_e;

  localparam int PRBS_LEN = 7;
endpackage

// File: rtl/ltpg_mode_guard.sv
module ltpg_mode_guard
  import ltpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_mode,
  output tp_mode_e   eff_mode
);
  // Set once the fast toggle has been requested; cleared only by a pass request.
  logic fast_seen;
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_seen <= 1'b0;
      armed     <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (req_mode == MODE_FAST)
        fast_seen <= 1'b1;
      else if (req_mode == MODE_PASS)
        fast_seen <= 1'b0;
    end
  end

  always_comb begin
    eff_mode = tp_mode_e'(req_mode);
    if (req_mode == MODE_SLOW && fast_seen)
      eff_mode = MODE_PASS;
  end

  // R6: a slow request right after a fast request is never applied
  a_r6_no_fast_to_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(req_mode) == MODE_FAST && req_mode == MODE_SLOW)
      |-> eff_mode == MODE_PASS);
endmodule

// File: rtl/ltpg_prbs_engine.sv
module ltpg_prbs_engine
  import ltpg_pkg::*;
#(
  parameter int                    SYM_W = 10,
  parameter logic [PRBS_LEN-1:0]   SEED  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [SYM_W-1:0] sym
);
  logic [PRBS_LEN-1:0] state;
  logic [PRBS_LEN-1:0] state_nxt;

  // Unroll SYM_W steps; bit 0 of the symbol is the earliest bit.
  always_comb begin
    logic [PRBS_LEN-1:0] s;
    logic                b;
    s   = state;
    sym = '0;
    for (int k = 0; k < SYM_W; k++) begin
      b      = s[PRBS_LEN-1] ^ s[PRBS_LEN-2];
      sym[k] = b;
      s      = {s[PRBS_LEN-2:0], b};
    end
    state_nxt = s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= SEED;
    else if (adv) state <= state_nxt;
  end

  // R3: the register never locks into the all-zero state
  a_r3_prbs_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  // R8: no advance without a transfer
  a_r8_prbs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state));
endmodule

// File: rtl/ltpg_toggle_engine.sv
module ltpg_toggle_engine #(
  parameter int SYM_W    = 10,
  parameter int SLOW_RUN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_adv,
  input  logic             fast_adv,
  output logic [SYM_W-1:0] slow_sym,
  output logic [SYM_W-1:0] fast_sym
);
  localparam int SLOW_PER = 2 * SLOW_RUN;
  localparam int PH_W     = $clog2(SLOW_PER);

  logic [PH_W-1:0] slow_ph;
  logic            fast_ph;

  // Bit k of the slow symbol: is (phase+k) in the second half of the period?
  always_comb begin
    for (int k = 0; k < SYM_W; k++) begin
      slow_sym[k] = (((int'(slow_ph) + k) % SLOW_PER) >= SLOW_RUN);
      fast_sym[k] = (((int'(fast_ph) + k) % 2) == 0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_ph <= '0;
      fast_ph <= 1'b0;
    end else begin
      if (slow_adv) slow_ph <= PH_W'((int'(slow_ph) + SYM_W) % SLOW_PER);
      if (fast_adv) fast_ph <= fast_ph ^ 1'(SYM_W % 2);
    end
  end
endmodule

// File: rtl/link_test_pattern_gen.sv
module link_test_pattern_gen
  import ltpg_pkg::*;
#(
  parameter int                  NUM_LANES = 3,
  parameter int                  SYM_W     = 10,
  parameter int                  SLOW_RUN  = 5,
  parameter logic [PRBS_LEN-1:0] PRBS_SEED = '1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pix_clk_present,
  input  logic [1:0]                 mode_sel,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [NUM_LANES*SYM_W-1:0] in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [NUM_LANES*SYM_W-1:0] out_data
);
  tp_mode_e         eff_mode;
  logic             xfer;
  logic             pat_on;
  logic [SYM_W-1:0] prbs_sym, slow_sym, fast_sym, pat_sym;
  logic             past_ok;

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign xfer      = in_valid && out_ready;
  assign pat_on    = pix_clk_present && (eff_mode != MODE_PASS);

  ltpg_mode_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_mode (mode_sel),
    .eff_mode (eff_mode)
  );

  ltpg_prbs_engine #(.SYM_W(SYM_W), .SEED(PRBS_SEED)) u_prbs (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (xfer && pix_clk_present && eff_mode == MODE_PRBS),
    .sym   (prbs_sym)
  );

  ltpg_toggle_engine #(.SYM_W(SYM_W), .SLOW_RUN(SLOW_RUN)) u_toggle (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_adv (xfer && pix_clk_present && eff_mode == MODE_SLOW),
    .fast_adv (xfer && pix_clk_present && eff_mode == MODE_FAST),
    .slow_sym (slow_sym),
    .fast_sym (fast_sym)
  );

  always_comb begin
    unique case (eff_mode)
      MODE_PRBS: pat_sym = prbs_sym;
      MODE_SLOW: pat_sym = slow_sym;
      MODE_FAST: pat_sym = fast_sym;
      default:   pat_sym = '0;
    endcase
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign out_data[l*SYM_W +: SYM_W] = pat_on ? pat_sym : in_data[l*SYM_W +: SYM_W];
    if (l > 0) begin : g_eq
      // R7: every lane matches lane 0 while a pattern is sent
      a_r7_lanes_equal: assert property (@(posedge clk) disable iff (!rst_n)
        pat_on |-> out_data[l*SYM_W +: SYM_W] == out_data[SYM_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R8: a stalled pattern shows the same symbol on the next cycle
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && pat_on && $past(pat_on) && $past(eff_mode) == eff_mode && !$past(xfer))
      |-> pat_sym == $past(pat_sym));
endmodule

// File: tb/link_test_pattern_gen_bench.sv
module link_test_pattern_gen_bench;
  localparam int L = 3;
  localparam int W = 10;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           pix_clk_present;
  logic [1:0]     mode_sel;
  logic           in_valid, in_ready, out_valid, out_ready;
  logic [L*W-1:0] in_data, out_data;

  int  checks = 0;
  int  errors = 0;
  int  pidx   = 0;
  bit  done   = 0;
  bit  pbits [0:1799];

  always #10 clk = ~clk;

  link_test_pattern_gen u_link_test_pattern_gen (
    .clk(clk), .rst_n(rst_n), .pix_clk_present(pix_clk_present), .mode_sel(mode_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [L*W-1:0] rep(input logic [W-1:0] s);
    return {L{s}};
  endfunction

  function automatic logic [W-1:0] prbs_sym(input int t);
    logic [W-1:0] s;
    for (int k = 0; k < W; k++) s[k] = pbits[7 + W*t + k];
    return s;
  endfunction

  task automatic chk(input string req, input logic [L*W-1:0] act, input logic [L*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic v, input logic r,
                       input logic p, input int seed);
    @(negedge clk);
    mode_sel        = m;
    in_valid        = v;
    out_ready       = r;
    pix_clk_present = p;
    in_data         = {10'(seed*13+5), 10'(seed*7+1), 10'(seed*3+2)};
    #2;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) pbits[i] = 1'b1;
    for (int i = 7; i < 1800; i++) pbits[i] = pbits[i-6] ^ pbits[i-7];

    rst_n = 1'b0; mode_sel = 2'd0; in_valid = 0; out_ready = 0;
    pix_clk_present = 1'b1; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state: pass-through
    drive(2'd0, 1, 1, 1, 1);
    chk("R1 pass after reset", out_data, in_data);

    // R2 pass-through sweep over handshake combinations
    for (int t = 0; t < 16; t++) begin
      drive(2'd0, t[0], t[1], 1, t + 40);
      chk("R2 pass data", out_data, in_data);
      chk("R2 handshake", {28'd0, out_valid, in_ready}, {28'd0, in_valid, out_ready});
    end

    // R1/R3/R7/R8 PRBS with stalls
    for (int t = 0; t < 160; t++) begin
      logic v, r;
      v = (t % 7 != 3);
      r = (t % 5 != 2);
      drive(2'd1, v, r, 1, t);
      if (t == 0) chk("R1 seed first symbol", out_data, rep(prbs_sym(0)));
      else if (v && r) chk("R3 R7 prbs symbol", out_data, rep(prbs_sym(pidx)));
      else chk("R8 prbs stalled hold", out_data, rep(prbs_sym(pidx)));
      if (v && r) pidx++;
    end

    // R8 another mode in between, then resume
    for (int t = 0; t < 4; t++) begin
      drive(2'd0, 1, 1, 1, t + 90);
      chk("R2 pass between prbs", out_data, in_data);
    end
    for (int t = 0; t < 5; t++) begin
      drive(2'd1, 1, 1, 1, t);
      chk("R8 prbs resume", out_data, rep(prbs_sym(pidx)));
      pidx++;
    end

    // R9 clock absent
    for (int t = 0; t < 4; t++) begin
      drive(2'd1, 1, 1, 0, t + 70);
      chk("R9 no clock pass", out_data, in_data);
    end
    for (int t = 0; t < 3; t++) begin
      drive(2'd1, 1, 1, 1, t);
      chk("R9 prbs not advanced", out_data, rep(prbs_sym(pidx)));
      pidx++;
    end

    // R4 slow toggle (no fast seen yet)
    for (int t = 0; t < 6; t++) begin
      drive(2'd2, t[0], 1, 1, t);
      chk("R4 slow toggle", out_data, rep(10'h3E0));
    end
    // R5 fast toggle
    for (int t = 0; t < 6; t++) begin
      drive(2'd3, 1, t[1], 1, t);
      chk("R5 fast toggle", out_data, rep(10'h155));
    end

    // R6 guard: slow refused after fast
    for (int t = 0; t < 3; t++) begin
      drive(2'd2, 1, 1, 1, t + 20);
      chk("R6 slow refused", out_data, in_data);
    end
    drive(2'd3, 1, 1, 1, 0);
    chk("R5 fast again", out_data, rep(10'h155));
    drive(2'd2, 1, 1, 1, 33);
    chk("R6 slow refused again", out_data, in_data);
    drive(2'd0, 1, 1, 1, 34);
    chk("R6 pass step", out_data, in_data);
    for (int t = 0; t < 3; t++) begin
      drive(2'd2, 1, 1, 1, t);
      chk("R6 slow honoured after pass", out_data, rep(10'h3E0));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule